// File: doc/BRIEF.md
# ISA-to-PCI Memory Forwarding Decoder

This block decides, for each memory cycle started by an ISA master or a DMA channel, whether the cycle is passed up to the PCI bus or kept on ISA. It holds one 8-bit read/write control byte. The upper nibble sets the top of an extended-memory window that starts at 1 MB, in 1 MB steps. The lower nibble enables forwarding for four fixed blocks below 1 MB.

Two more inputs shape the decision. An inclusive address hole, given by base and top inputs, is cut out of the extended window. A BIOS chip-select enable input keeps low-BIOS cycles on ISA whatever the control byte holds. The result is a single forward flag, registered one clock after the cycle strobe is sampled.

Top module: `isa_fwd_decoder`

## Requirements
- R1: After reset the control byte reads 01h (top code 0, only the 0–512 KB block enabled), and the forward flag is 0.
- R2: A write loads the whole control byte. It reads back on the next cycle: bits 7:4 are the window top code and bits 3:0 are the block enables.
- R3: With top code n (bits 7:4), addresses from 100000h up to and including ((n+1)·1 MB)−1 are forwarded. The next address above that is not forwarded.
- R4: An extended-window address with hole base ≤ address ≤ hole top is not forwarded. The hole has no effect on addresses below 1 MB.
- R5: Top code 0 leaves the extended window empty, so no address at or above 1 MB is forwarded.
- R6: Bit 0 forwards 00000h–7FFFFh when set and keeps that block on ISA when clear.
- R7: Bit 1 forwards 80000h–9FFFFh and bit 2 forwards A0000h–BFFFFh. Each block follows only its own bit.
- R8: With the BIOS chip-select enable at 0, E0000h–EFFFFh is forwarded exactly when bit 3 is set.
- R9: With the BIOS chip-select enable at 1, E0000h–EFFFFh is never forwarded, even when bit 3 is set.
- R10: C0000h–DFFFFh and F0000h–FFFFFh are never forwarded, whatever the control byte holds.
- R11: The forward flag is a register. It shows the decision for the address sampled with the strobe high on the previous clock edge, and is 0 after any edge where the strobe was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read data |
| cyc_valid_i | input | 1 | Memory cycle strobe |
| addr_i | input | 24 | ISA memory address |
| hole_base_i | input | 24 | Lowest address of the hole (inclusive) |
| hole_top_i | input | 24 | Highest address of the hole (inclusive) |
| bios_cs_en_i | input | 1 | BIOS chip-select enable; keeps low BIOS on ISA |
| fwd_o | output | 1 | Forward cycle to PCI, registered |

## Verification
The bench tests the last byte of the extended window and the first byte above it. A decoder with an exclusive top, or one that reads the code as the top itself, would misjudge one of those two addresses. It also tests both edges of the hole and a hole placed below 1 MB. An off-by-one compare, or a hole applied to low memory, would wrongly drop a cycle. It drives low-BIOS cycles with bit 3 set and the chip-select enable in both states, so a lost override would forward a cycle that belongs on ISA. The two blocks below 1 MB that have no enable bit are tested with every enable set, so a loose segment decode would forward them.

// File: rtl/isa_fwd_pkg.sv
package isa_fwd_pkg;
  typedef struct packed {
    logic [3:0] top_code;
    logic [3:0] blk_en;
  } cfg_t;

  localparam logic [7:0] CFG_RST = 8'h01;

  // enable bit index per low block
  localparam int unsigned BLK_BASE = 0;
  localparam int unsigned BLK_HIGH = 1;
  localparam int unsigned BLK_VGA  = 2;
  localparam int unsigned BLK_BIOS = 3;
endpackage

// File: rtl/isa_fwd_cfg_reg.sv
module isa_fwd_cfg_reg
  import isa_fwd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= cfg_t'(CFG_RST);
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_o == cfg_t'($past(wdata_i))));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/isa_fwd_low_dec.sv
module isa_fwd_low_dec
  import isa_fwd_pkg::*;
#(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic [3:0]      blk_en_i,
  input  logic            bios_cs_en_i,
  output logic            hit_o
);
  localparam int unsigned MB_W = HI_W - 4;

  logic [3:0] seg;  // 64 KB segment within the first MB
  logic       below_mb;

  assign seg      = addr_hi_i[3:0];
  assign below_mb = (addr_hi_i[HI_W-1:4] == '0);

  always_comb begin
    hit_o = 1'b0;
    if (below_mb) begin
      unique case (seg)
        4'h0, 4'h1, 4'h2, 4'h3,
        4'h4, 4'h5, 4'h6, 4'h7: hit_o = blk_en_i[BLK_BASE];
        4'h8, 4'h9:             hit_o = blk_en_i[BLK_HIGH];
        4'hA, 4'hB:             hit_o = blk_en_i[BLK_VGA];
        4'hE:                   hit_o = blk_en_i[BLK_BIOS] && !bios_cs_en_i;
        default:                hit_o = 1'b0;
      endcase
    end
  end

  // R10
  low_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_mb && (seg == 4'hC || seg == 4'hD || seg == 4'hF)) |-> !hit_o);
  // R9
  low_bios_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_mb && seg == 4'hE && bios_cs_en_i) |-> !hit_o);
  // R10
  low_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i[HI_W-1:4] != {MB_W{1'b0}}) |-> !hit_o);
endmodule

// File: rtl/isa_fwd_ext_dec.sv
module isa_fwd_ext_dec #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned MB_SH  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        top_code_i,
  input  logic [ADDR_W-1:0] hole_base_i,
  input  logic [ADDR_W-1:0] hole_top_i,
  output logic              hit_o
);
  localparam int unsigned MB_W = ADDR_W - MB_SH;

  logic [MB_W-1:0] mb_idx;
  logic            in_win, in_hole;

  assign mb_idx  = addr_i[ADDR_W-1:MB_SH];
  // code n covers MB indices 1..n, i.e. up to ((n+1) MB) - 1 inclusive
  assign in_win  = (mb_idx != '0) && (mb_idx <= MB_W'(top_code_i));
  assign in_hole = (addr_i >= hole_base_i) && (addr_i <= hole_top_i);
  assign hit_o   = in_win && !in_hole;

  // R5
  ext_code0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_code_i == 4'h0) |-> !hit_o);
  // R4
  ext_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= hole_base_i && addr_i <= hole_top_i) |-> !hit_o);
endmodule

// File: rtl/isa_fwd_decoder.sv
module isa_fwd_decoder
  import isa_fwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              cyc_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] hole_base_i,
  input  logic [ADDR_W-1:0] hole_top_i,
  input  logic              bios_cs_en_i,
  output logic              fwd_o
);
  localparam int unsigned MB_SH  = 20;
  localparam int unsigned SEG_SH = 16;
  localparam int unsigned HI_W   = ADDR_W - SEG_SH;

  cfg_t cfg;
  logic low_hit, ext_hit, fwd_q;

  isa_fwd_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  isa_fwd_low_dec #(.HI_W(HI_W)) u_low (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_hi_i    (addr_i[ADDR_W-1:SEG_SH]),
    .blk_en_i     (cfg.blk_en),
    .bios_cs_en_i (bios_cs_en_i),
    .hit_o        (low_hit)
  );

  isa_fwd_ext_dec #(.ADDR_W(ADDR_W), .MB_SH(MB_SH)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .top_code_i  (cfg.top_code),
    .hole_base_i (hole_base_i),
    .hole_top_i  (hole_top_i),
    .hit_o       (ext_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= 1'b0;
    else         fwd_q <= cyc_valid_i && (low_hit || ext_hit);
  end

  assign fwd_o       = fwd_q;
  assign cfg_rdata_o = cfg;

  // R11
  fwd_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(cyc_valid_i));
  // R3
  fwd_above_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && addr_i[ADDR_W-1:MB_SH] > (ADDR_W-MB_SH)'(cfg.top_code)) |=> !fwd_o);
  // R11
  low_ext_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_hit && ext_hit));
endmodule

// File: tb/isa_fwd_decoder_bench.sv
`timescale 1ns/1ps
module isa_fwd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic [23:0] addr = '0;
  logic [23:0] hole_base = 24'hFFFFFF;
  logic [23:0] hole_top = 24'h000000;
  logic        bios_cs_en = 1'b0;
  logic        fwd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  isa_fwd_decoder u_isa_fwd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cyc_valid_i(cyc_valid), .addr_i(addr),
    .hole_base_i(hole_base), .hole_top_i(hole_top), .bios_cs_en_i(bios_cs_en),
    .fwd_o(fwd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic probe(string req, logic [23:0] a, bit exp);
    @(negedge clk); cyc_valid = 1'b1; addr = a;
    @(posedge clk); #1;
    check(req, {31'b0, fwd}, {31'b0, exp});
    @(negedge clk); cyc_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 rdata", {24'b0, cfg_rdata}, 32'h01);
    check("R1 fwd", {31'b0, fwd}, 0);
  endtask

  task automatic t_rw;
    write_cfg(8'h5A);
    check("R2 readback", {24'b0, cfg_rdata}, 32'h5A);
    write_cfg(8'hC3);
    check("R2 readback", {24'b0, cfg_rdata}, 32'hC3);
  endtask

  task automatic t_ext;
    write_cfg(8'h30);
    probe("R3 first", 24'h100000, 1);
    probe("R3 last", 24'h3FFFFF, 1);
    probe("R3 above", 24'h400000, 0);
    write_cfg(8'hF0);
    probe("R3 max", 24'hFFFFFF, 1);
    write_cfg(8'h00);
    probe("R5 code0", 24'h100000, 0);
    probe("R5 code0 hi", 24'h8ABCDE, 0);
  endtask

  task automatic t_hole;
    write_cfg(8'h71);
    hole_base = 24'h200000; hole_top = 24'h2FFFFF;
    probe("R4 inside", 24'h250000, 0);
    probe("R4 base", 24'h200000, 0);
    probe("R4 top", 24'h2FFFFF, 0);
    probe("R4 below", 24'h1FFFFF, 1);
    probe("R4 above", 24'h300000, 1);
    hole_base = 24'h000000; hole_top = 24'h0FFFFF;
    probe("R4 low unaffected", 24'h010000, 1);
    hole_base = 24'hFFFFFF; hole_top = 24'h000000;
  endtask

  task automatic t_low;
    write_cfg(8'h01);
    probe("R6 on", 24'h07FFFF, 1);
    probe("R7 512k off", 24'h080000, 0);
    write_cfg(8'h00);
    probe("R6 off", 24'h000000, 0);
    write_cfg(8'h02);
    probe("R7 512k on", 24'h09FFFF, 1);
    probe("R7 vga off", 24'h0A0000, 0);
    write_cfg(8'h04);
    probe("R7 vga on", 24'h0BFFFF, 1);
    probe("R7 512k off2", 24'h080000, 0);
  endtask

  task automatic t_bios;
    write_cfg(8'h08);
    bios_cs_en = 1'b0;
    probe("R8 on", 24'h0E8000, 1);
    write_cfg(8'h07);
    probe("R8 off", 24'h0E0000, 0);
    write_cfg(8'hFF);
    bios_cs_en = 1'b1;
    probe("R9 override", 24'h0EFFFF, 0);
    probe("R9 other blocks", 24'h000100, 1);
    bios_cs_en = 1'b0;
  endtask

  task automatic t_gap;
    write_cfg(8'hFF);
    probe("R10 C seg", 24'h0C0000, 0);
    probe("R10 D seg", 24'h0DFFFF, 0);
    probe("R10 F seg", 24'h0F0000, 0);
    probe("R10 top", 24'h0FFFFF, 0);
  endtask

  task automatic t_strobe;
    write_cfg(8'hFF);
    @(negedge clk); cyc_valid = 1'b0; addr = 24'h100000;
    @(posedge clk); #1;
    check("R11 no strobe", {31'b0, fwd}, 0);
    @(negedge clk); cyc_valid = 1'b1;
    #0.5;
    check("R11 registered", {31'b0, fwd}, 0);
    @(posedge clk); #1;
    check("R11 after edge", {31'b0, fwd}, 1);
    @(negedge clk); cyc_valid = 1'b0;
    @(posedge clk); #1;
    check("R11 drop", {31'b0, fwd}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_rw;
    t_ext;
    t_hole;
    t_low;
    t_bios;
    t_gap;
    t_strobe;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule